// File: doc/BRIEF.md
# RISC Integer Execute Unit

This block executes one 32-bit instruction of a small load/store RISC instruction set per clock. It owns the 32-entry general register file and the four integer status flags. From the instruction word, the current program counter and, for loads, a data word supplied by the surrounding memory, it works out four things in the same cycle: the value to write back, the address of the next instruction, the data-memory address, and a load or store strobe. Register and flag updates take effect at the next rising clock edge when the instruction is marked valid.

The two top bits of the word select one of four formats. These are a constant/branch format, a call with a 30-bit word displacement, a three-operand arithmetic format, and a memory format. In the arithmetic and memory formats bit 13 selects either a second register or a sign-extended 13-bit constant as the second operand. Conditional branches test the stored flags. Call and jump-and-link leave the current PC in a register, so that a later jump-and-link can return.

Top module: `rx_exec_unit`

## Requirements
- R1: Bits 31:30 pick the format: 00 constant/branch, 01 call, 10 arithmetic, 11 memory. An op3 code (bits 24:19) not listed in R3, R8 or R10, or a format-00 op2 (bits 24:22) other than 100 or 010, writes no register, raises no strobe, leaves the flags unchanged and gives next PC = PC + 4.
- R2: In formats 10 and 11, bit 13 = 0 takes the second operand from the register named by bits 4:0. Bit 13 = 1 takes bits 12:0 sign-extended to 32 bits.
- R3: The arithmetic op3 codes are 010000 add, 010001 AND, 010010 OR, 010110 NOR and 100110 logical right shift. The shift count is the low 5 bits of the second operand. Each writes its result to the register in bits 29:25, and next PC = PC + 4.
- R4: flags_o is {n,z,v,c} in bits 3:0. Add, AND, OR and NOR set n = result bit 31 and z = (result == 0). Add also sets c = carry out and v = signed overflow, while the logic operations clear v and c. Every other instruction leaves the flags unchanged.
- R5: Format 00 with op2 = 100 writes {bits 21:0, ten zero bits} to the register in bits 29:25.
- R6: Format 00 with op2 = 010 is a branch whose condition sits in bits 28:25. The codes are 0001 (z), 0101 (c), 0110 (n), 0111 (v) and 1000 (always); every other code is never taken. A taken branch gives next PC = PC + (sign-extended bits 21:0 shifted left by 2), and an untaken one gives PC + 4.
- R7: A call gives next PC = PC + (bits 29:0 shifted left by 2) and writes the current PC into register 15.
- R8: Arithmetic op3 111000 (jump-and-link) gives next PC = rs1 (bits 18:14) + second operand and writes the current PC into the register in bits 29:25.
- R9: Register 0 always reads as zero. An instruction targeting it keeps rd_we_o low but still updates the flags where R4 says so.
- R10: Memory op3 000000 loads: it raises ld_o and writes ld_data_i to the register in bits 29:25. Memory op3 000100 stores: it raises st_o and drives st_data_o with that register. Both put rs1 + second operand on mem_addr_o, and next PC = PC + 4.
- R11: Outputs follow the inputs combinationally. Registers and flags change only at a rising edge with valid_i high. With valid_i low there is no write, no strobe and no flag change. Reset clears all registers and flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction on insn_i is to be executed |
| insn_i | input | 32 | Instruction word |
| pc_i | input | 32 | Address of the instruction |
| ld_data_i | input | 32 | Data returned for a load |
| rd_idx_o | output | 5 | Destination register index |
| rd_we_o | output | 1 | Register write this cycle |
| result_o | output | 32 | Value written back |
| next_pc_o | output | 32 | Address of the next instruction |
| mem_addr_o | output | 32 | Data-memory address |
| ld_o | output | 1 | Load strobe |
| st_o | output | 1 | Store strobe |
| st_data_o | output | 32 | Store data |
| flags_o | output | 4 | Status flags {n,z,v,c} |

## Verification
The assertions assume that valid_i, insn_i and pc_i are stable across each rising edge and are never X while reset is released. They also assume that the caller presents ld_data_i in the same cycle as the load. The bench drives every input at the falling edge and holds it until the following falling edge, so each instruction sees exactly one rising edge. The register file is loaded only through ordinary instructions, so every stored value and flag state the sweeps use comes from a legal instruction sequence.

// File: rtl/rx_pkg.sv
package rx_pkg;

   typedef enum logic [1:0] {
      FMT_SB    = 2'b00,
      FMT_CALL  = 2'b01,
      FMT_ARITH = 2'b10,
      FMT_MEM   = 2'b11
   } fmt_e;

   localparam logic [2:0] OP2_BRANCH = 3'b010;
   localparam logic [2:0] OP2_SETHI  = 3'b100;

   localparam logic [5:0] OP3_ADD  = 6'b010000;
   localparam logic [5:0] OP3_AND  = 6'b010001;
   localparam logic [5:0] OP3_OR   = 6'b010010;
   localparam logic [5:0] OP3_NOR  = 6'b010110;
   localparam logic [5:0] OP3_SRL  = 6'b100110;
   localparam logic [5:0] OP3_JMPL = 6'b111000;
   localparam logic [5:0] OP3_LD   = 6'b000000;
   localparam logic [5:0] OP3_ST   = 6'b000100;

   localparam logic [3:0] CND_ZERO  = 4'b0001;
   localparam logic [3:0] CND_CARRY = 4'b0101;
   localparam logic [3:0] CND_NEG   = 4'b0110;
   localparam logic [3:0] CND_OVF   = 4'b0111;
   localparam logic [3:0] CND_ALWAYS = 4'b1000;

   typedef enum logic [2:0] {ALU_ADD, ALU_AND, ALU_OR, ALU_NOR, ALU_SRL} alu_op_e;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } ccr_t;

   function automatic logic cond_met(input logic [3:0] cnd, input ccr_t f);
      case (cnd)
         CND_ZERO:   return f.z;
         CND_CARRY:  return f.c;
         CND_NEG:    return f.n;
         CND_OVF:    return f.v;
         CND_ALWAYS: return 1'b1;
         default:    return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/rx_regfile.sv
module rx_regfile #(
   parameter int XLEN = 32,
   parameter int NREG = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we_i,
   input  logic [$clog2(NREG)-1:0] wa_i,
   input  logic [XLEN-1:0]         wd_i,
   input  logic [$clog2(NREG)-1:0] ra_a_i,
   input  logic [$clog2(NREG)-1:0] ra_b_i,
   input  logic [$clog2(NREG)-1:0] ra_c_i,
   output logic [XLEN-1:0]         rd_a_o,
   output logic [XLEN-1:0]         rd_b_o,
   output logic [XLEN-1:0]         rd_c_o
);
   localparam int AW = $clog2(NREG);

   if (NREG != (1 << AW)) begin : g_bad_depth
      $error("rx_regfile: NREG must be a power of two");
   end

   logic [XLEN-1:0] row [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_row
      if (g == 0) begin : g_zero
         assign row[g] = '0;
      end else begin : g_store
         logic [XLEN-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (we_i && wa_i == AW'(g))
               q <= wd_i;
         end
         assign row[g] = q;
      end
   end

   assign rd_a_o = row[ra_a_i];
   assign rd_b_o = row[ra_b_i];
   assign rd_c_o = row[ra_c_i];

   // R11: a write to a nonzero register is visible in the next cycle
   p_write_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && wa_i != '0) |=> (row[$past(wa_i)] == $past(wd_i)));

endmodule

// File: rtl/rx_alu.sv
module rx_alu
   import rx_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   input  alu_op_e         op_i,
   output logic [XLEN-1:0] y_o,
   output ccr_t            cc_o
);
   localparam int SHW = $clog2(XLEN);

   logic [XLEN:0] sum;

   always_comb begin
      sum    = {1'b0, a_i} + {1'b0, b_i};
      cc_o.v = 1'b0;
      cc_o.c = 1'b0;
      case (op_i)
         ALU_ADD: begin
            y_o    = sum[XLEN-1:0];
            cc_o.c = sum[XLEN];
            cc_o.v = (a_i[XLEN-1] == b_i[XLEN-1]) && (sum[XLEN-1] != a_i[XLEN-1]);
         end
         ALU_AND: y_o = a_i & b_i;
         ALU_OR:  y_o = a_i | b_i;
         ALU_NOR: y_o = ~(a_i | b_i);
         ALU_SRL: y_o = a_i >> b_i[SHW-1:0];
         default: y_o = a_i;
      endcase
      cc_o.n = y_o[XLEN-1];
      cc_o.z = (y_o == '0);
   end

endmodule

// File: rtl/rx_npc.sv
module rx_npc
   import rx_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] pc_i,
   input  logic            br_en_i,
   input  logic            call_en_i,
   input  logic            jmp_en_i,
   input  logic [3:0]      cond_i,
   input  logic [21:0]     disp22_i,
   input  logic [XLEN-3:0] disp30_i,
   input  logic [XLEN-1:0] jmp_tgt_i,
   input  ccr_t            cc_i,
   output logic [XLEN-1:0] next_pc_o
);
   logic [XLEN-1:0] seq_pc, br_pc, call_pc;

   always_comb begin
      seq_pc  = pc_i + XLEN'(4);
      br_pc   = pc_i + {{(XLEN-24){disp22_i[21]}}, disp22_i, 2'b00};
      call_pc = pc_i + {disp30_i, 2'b00};
      if (jmp_en_i)
         next_pc_o = jmp_tgt_i;
      else if (call_en_i)
         next_pc_o = call_pc;
      else if (br_en_i && cond_met(cond_i, cc_i))
         next_pc_o = br_pc;
      else
         next_pc_o = seq_pc;
   end

endmodule

// File: rtl/rx_exec_unit.sv
module rx_exec_unit
   import rx_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter int NREG     = 32,
   parameter int LINK_REG = 15
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    valid_i,
   input  logic [XLEN-1:0]         insn_i,
   input  logic [XLEN-1:0]         pc_i,
   input  logic [XLEN-1:0]         ld_data_i,
   output logic [$clog2(NREG)-1:0] rd_idx_o,
   output logic                    rd_we_o,
   output logic [XLEN-1:0]         result_o,
   output logic [XLEN-1:0]         next_pc_o,
   output logic [XLEN-1:0]         mem_addr_o,
   output logic                    ld_o,
   output logic                    st_o,
   output logic [XLEN-1:0]         st_data_o,
   output logic [3:0]              flags_o
);
   localparam int AW   = $clog2(NREG);
   localparam int IMMW = 13;

   if (XLEN != 32) begin : g_bad_xlen
      $error("rx_exec_unit: instruction encoding fixes XLEN at 32");
   end
   if (NREG != 32) begin : g_bad_nreg
      $error("rx_exec_unit: register fields are 5 bits, NREG must be 32");
   end
   if (LINK_REG <= 0 || LINK_REG >= NREG) begin : g_bad_link
      $error("rx_exec_unit: LINK_REG out of range");
   end

   // field split
   fmt_e            fmt;
   logic [AW-1:0]   f_rd, f_rs1, f_rs2;
   logic [2:0]      f_op2;
   logic [5:0]      f_op3;
   logic            f_imm;
   logic [IMMW-1:0] f_simm;
   logic [XLEN-1:0] simm_ext;

   assign fmt      = fmt_e'(insn_i[31:30]);
   assign f_rd     = insn_i[29:25];
   assign f_op2    = insn_i[24:22];
   assign f_op3    = insn_i[24:19];
   assign f_rs1    = insn_i[18:14];
   assign f_imm    = insn_i[13];
   assign f_simm   = insn_i[IMMW-1:0];
   assign f_rs2    = insn_i[4:0];
   assign simm_ext = {{(XLEN-IMMW){f_simm[IMMW-1]}}, f_simm};

   // register file
   logic            rf_we;
   logic [AW-1:0]   dst;
   logic [XLEN-1:0] src_a, src_b, src_d, opnd_b, addr_sum;

   rx_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
      .clk    (clk),
      .rst_n  (rst_n),
      .we_i   (rf_we),
      .wa_i   (dst),
      .wd_i   (result_o),
      .ra_a_i (f_rs1),
      .ra_b_i (f_rs2),
      .ra_c_i (f_rd),
      .rd_a_o (src_a),
      .rd_b_o (src_b),
      .rd_c_o (src_d)
   );

   assign opnd_b   = f_imm ? simm_ext : src_b;
   assign addr_sum = src_a + opnd_b;

   // ALU
   alu_op_e         alu_op;
   logic [XLEN-1:0] alu_y;
   ccr_t            alu_cc;

   rx_alu #(.XLEN(XLEN)) u_alu (
      .a_i  (src_a),
      .b_i  (opnd_b),
      .op_i (alu_op),
      .y_o  (alu_y),
      .cc_o (alu_cc)
   );

   // decode
   logic wr_req, cc_we, is_ld, is_st, is_br, is_call, is_jmp;

   always_comb begin
      wr_req   = 1'b0;
      cc_we    = 1'b0;
      is_ld    = 1'b0;
      is_st    = 1'b0;
      is_br    = 1'b0;
      is_call  = 1'b0;
      is_jmp   = 1'b0;
      alu_op   = ALU_ADD;
      result_o = '0;
      case (fmt)
         FMT_SB: begin
            if (f_op2 == OP2_SETHI) begin
               wr_req   = 1'b1;
               result_o = {insn_i[21:0], {(XLEN-22){1'b0}}};
            end else if (f_op2 == OP2_BRANCH) begin
               is_br = 1'b1;
            end
         end
         FMT_CALL: begin
            is_call  = 1'b1;
            wr_req   = 1'b1;
            result_o = pc_i;
         end
         FMT_ARITH: begin
            case (f_op3)
               OP3_ADD: begin alu_op = ALU_ADD; wr_req = 1'b1; cc_we = 1'b1; result_o = alu_y; end
               OP3_AND: begin alu_op = ALU_AND; wr_req = 1'b1; cc_we = 1'b1; result_o = alu_y; end
               OP3_OR:  begin alu_op = ALU_OR;  wr_req = 1'b1; cc_we = 1'b1; result_o = alu_y; end
               OP3_NOR: begin alu_op = ALU_NOR; wr_req = 1'b1; cc_we = 1'b1; result_o = alu_y; end
               OP3_SRL: begin alu_op = ALU_SRL; wr_req = 1'b1; result_o = alu_y; end
               OP3_JMPL: begin is_jmp = 1'b1; wr_req = 1'b1; result_o = pc_i; end
               default: ;
            endcase
         end
         FMT_MEM: begin
            if (f_op3 == OP3_LD) begin
               is_ld    = 1'b1;
               wr_req   = 1'b1;
               result_o = ld_data_i;
            end else if (f_op3 == OP3_ST) begin
               is_st = 1'b1;
            end
         end
         default: ;
      endcase
   end

   assign dst        = is_call ? AW'(LINK_REG) : f_rd;
   assign rf_we      = valid_i && wr_req && (dst != '0);
   assign rd_we_o    = rf_we;
   assign rd_idx_o   = dst;
   assign ld_o       = valid_i && is_ld;
   assign st_o       = valid_i && is_st;
   assign mem_addr_o = addr_sum;
   assign st_data_o  = src_d;

   // status flags
   ccr_t cc_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cc_q <= '0;
      else if (valid_i && cc_we)
         cc_q <= alu_cc;
   end
   assign flags_o = cc_q;

   // next PC
   rx_npc #(.XLEN(XLEN)) u_npc (
      .pc_i      (pc_i),
      .br_en_i   (is_br),
      .call_en_i (is_call),
      .jmp_en_i  (is_jmp),
      .cond_i    (insn_i[28:25]),
      .disp22_i  (insn_i[21:0]),
      .disp30_i  (insn_i[XLEN-3:0]),
      .jmp_tgt_i (addr_sum),
      .cc_i      (cc_q),
      .next_pc_o (next_pc_o)
   );

   // R4: flags hold unless a flag-setting instruction executes
   p_flags_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(valid_i && cc_we) |=> $stable(flags_o));

   // R4: zero flag tracks the previous flag-setting result
   p_zero_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && cc_we) |=> (flags_o[2] == ($past(result_o) == '0)));

   // R10: never load and store at once
   p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ld_o, st_o}));

   // R9: register 0 is never the target of a write strobe
   p_no_r0_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_we_o |-> (rd_idx_o != '0));

   // R3: non-jump arithmetic falls through to the next word
   p_seq_pc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt == FMT_ARITH && f_op3 != OP3_JMPL) |-> (next_pc_o == pc_i + XLEN'(4)));

   // R11: an invalid slot produces no side effect
   p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |-> !(ld_o || st_o || rd_we_o));

endmodule

// File: tb/rx_exec_unit_bench.sv
module rx_exec_unit_bench;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_i = 1'b0;
   logic [31:0] insn_i = '0;
   logic [31:0] pc_i = '0;
   logic [31:0] ld_data_i = '0;
   logic [4:0]  rd_idx_o;
   logic        rd_we_o;
   logic [31:0] result_o, next_pc_o, mem_addr_o, st_data_o;
   logic        ld_o, st_o;
   logic [3:0]  flags_o;

   int checks = 0;
   int fails  = 0;

   always #(CLK_P/2) clk = ~clk;

   rx_exec_unit u_rx_exec_unit (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .insn_i(insn_i), .pc_i(pc_i),
      .ld_data_i(ld_data_i), .rd_idx_o(rd_idx_o), .rd_we_o(rd_we_o),
      .result_o(result_o), .next_pc_o(next_pc_o), .mem_addr_o(mem_addr_o),
      .ld_o(ld_o), .st_o(st_o), .st_data_o(st_data_o), .flags_o(flags_o)
   );

   // reference state
   logic [31:0] m_reg [32];
   logic [3:0]  m_fl;       // {n,z,v,c}
   logic [31:0] pc;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] f_arith(input logic [5:0] op3, input logic [4:0] rd,
                                           input logic [4:0] rs1, input logic i, input logic [12:0] lo);
      return {2'b10, rd, op3, rs1, i, lo};
   endfunction
   function automatic logic [31:0] f_mem(input logic [5:0] op3, input logic [4:0] rd,
                                         input logic [4:0] rs1, input logic i, input logic [12:0] lo);
      return {2'b11, rd, op3, rs1, i, lo};
   endfunction
   function automatic logic [31:0] f_sethi(input logic [4:0] rd, input logic [21:0] v);
      return {2'b00, rd, 3'b100, v};
   endfunction
   function automatic logic [31:0] f_br(input logic [3:0] c, input logic [21:0] d);
      return {2'b00, 1'b0, c, 3'b010, d};
   endfunction

   function automatic logic m_cond(input logic [3:0] c, input logic [3:0] f);
      case (c)
         4'b0001: return f[2];
         4'b0101: return f[0];
         4'b0110: return f[3];
         4'b0111: return f[1];
         4'b1000: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   task automatic run(input logic [31:0] insn, input logic [31:0] ldd, input logic vld, input string tag);
      logic [1:0]  op  = insn[31:30];
      logic [4:0]  rd  = insn[29:25];
      logic [5:0]  op3 = insn[24:19];
      logic [2:0]  op2 = insn[24:22];
      logic [31:0] a   = m_reg[insn[18:14]];
      logic [31:0] b   = insn[13] ? {{19{insn[12]}}, insn[12:0]} : m_reg[insn[4:0]];
      logic [31:0] sum = a + b;
      logic [32:0] wide;
      logic [31:0] val = '0, r = '0, npc;
      logic [4:0]  dst = rd;
      logic        wr = 0, fw = 0, e_ld = 0, e_st = 0, e_we;
      logic        vv = 0, cc = 0;
      npc = pc + 32'd4;
      case (op)
         2'b00: begin
            if (op2 == 3'b100) begin wr = 1; val = {insn[21:0], 10'b0}; end
            else if (op2 == 3'b010 && m_cond(insn[28:25], m_fl))
               npc = pc + {{8{insn[21]}}, insn[21:0], 2'b00};
         end
         2'b01: begin wr = 1; dst = 5'd15; val = pc; npc = pc + {insn[29:0], 2'b00}; end
         2'b10: begin
            case (op3)
               6'b010000: begin wide = {1'b0, a} + {1'b0, b}; r = wide[31:0]; cc = wide[32];
                  vv = (a[31] == b[31]) && (r[31] != a[31]); wr = 1; fw = 1; end
               6'b010001: begin r = a & b;    wr = 1; fw = 1; end
               6'b010010: begin r = a | b;    wr = 1; fw = 1; end
               6'b010110: begin r = ~(a | b); wr = 1; fw = 1; end
               6'b100110: begin r = a >> b[4:0]; wr = 1; end
               6'b111000: begin wr = 1; npc = sum; end
               default: ;
            endcase
            val = (op3 == 6'b111000) ? pc : r;
         end
         default: begin
            if (op3 == 6'b000000) begin e_ld = 1; wr = 1; val = ldd; end
            else if (op3 == 6'b000100) e_st = 1;
         end
      endcase
      e_we = vld && wr && (dst != 0);

      @(negedge clk);
      chk("R4 flags", {28'b0, flags_o}, {28'b0, m_fl});
      insn_i = insn; pc_i = pc; ld_data_i = ldd; valid_i = vld;
      #2;
      chk({tag, " we"}, {31'b0, rd_we_o}, {31'b0, e_we});
      if (e_we) begin
         chk({tag, " idx"}, {27'b0, rd_idx_o}, {27'b0, dst});
         chk({tag, " result"}, result_o, val);
      end
      if (vld) chk({tag, " next_pc"}, next_pc_o, npc);
      chk({tag, " strobes"}, {30'b0, ld_o, st_o}, {30'b0, vld && e_ld, vld && e_st});
      if (vld && (e_ld || e_st)) chk({tag, " addr"}, mem_addr_o, sum);
      if (vld && e_st) chk({tag, " st_data"}, st_data_o, m_reg[rd]);
      if (e_we) m_reg[dst] = val;
      if (vld && fw) m_fl = {r[31], r == 0, vv, cc};
      pc = pc + 32'd4;
   endtask

   task automatic load_reg(input logic [4:0] rn, input logic [31:0] v);
      run(f_sethi(rn, v[31:10]), 0, 1, "R5");
      run(f_arith(6'b010010, rn, rn, 1, {3'b0, v[9:0]}), 0, 1, "R2");
   endtask

   localparam logic [31:0] VALS [8] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                                        32'h8000_0000, 32'h1234_5678, 32'h0000_001F, 32'hA5A5_A5A5};
   localparam logic [12:0] IMMS [7] = '{13'h0000, 13'h0001, 13'h1FFF, 13'h0FFF,
                                        13'h1000, 13'h001F, 13'h0005};
   localparam logic [5:0]  OPS  [5] = '{6'b010000, 6'b010001, 6'b010010, 6'b010110, 6'b100110};
   localparam logic [4:0]  PA   [7] = '{5'd1, 5'd3, 5'd4, 5'd5, 5'd3, 5'd2, 5'd5};
   localparam logic [4:0]  PB   [7] = '{5'd1, 5'd2, 5'd2, 5'd5, 5'd3, 5'd2, 5'd3};

   initial begin
      for (int k = 0; k < 32; k++) m_reg[k] = '0;
      m_fl = '0;
      pc   = 32'h0000_4000;
      #(CLK_P * 2);
      // reset state (R11)
      chk("R11 reset we", {31'b0, rd_we_o}, 32'b0);
      chk("R11 reset flags", {28'b0, flags_o}, 32'b0);
      @(negedge clk); rst_n = 1'b1;
      run(f_mem(6'b000100, 5'd6, 5'd0, 1, 13'h0010), 0, 1, "R11 reset reg");

      // load operands r1..r8
      for (int k = 0; k < 8; k++) load_reg(5'(k + 1), VALS[k]);

      // register-register ALU sweep (R3, R4)
      for (int o = 0; o < 5; o++)
         for (int x = 1; x <= 8; x++)
            for (int y = 1; y <= 8; y++)
               run(f_arith(OPS[o], 5'(9 + (x + y) % 20), 5'(x), 0, {8'b0, 5'(y)}), 0, 1, "R3");
      // immediate ALU sweep (R2)
      for (int o = 0; o < 5; o++)
         for (int x = 1; x <= 8; x++)
            for (int m = 0; m < 7; m++)
               run(f_arith(OPS[o], 5'(9 + (x + m) % 20), 5'(x), 1, IMMS[m]), 0, 1, "R2");

      // register 0 (R9)
      run(f_arith(6'b010000, 5'd0, 5'd3, 0, 13'd3), 0, 1, "R9 write r0");
      run(f_mem(6'b000100, 5'd0, 5'd1, 1, 13'd8), 0, 1, "R9 read r0");
      run(f_sethi(5'd0, 22'h3FFFFF), 0, 1, "R9 sethi r0");

      // sethi sweep (R5)
      run(f_sethi(5'd20, 22'h000001), 0, 1, "R5");
      run(f_sethi(5'd21, 22'h3FFFFF), 0, 1, "R5");
      run(f_sethi(5'd22, 22'h2AAAAA), 0, 1, "R5");

      // branches over all conditions and reachable flag states (R6)
      for (int s = 0; s < 7; s++) begin
         run(f_arith(6'b010000, 5'd0, PA[s], 0, {8'b0, PB[s]}), 0, 1, "R4 set");
         for (int c = 0; c < 16; c++) begin
            run(f_br(4'(c), 22'h000010), 0, 1, "R6 fwd");
            run(f_br(4'(c), 22'h3FFFF0), 0, 1, "R6 back");
         end
      end

      // call / jump-and-link (R7, R8)
      run({2'b01, 30'h0000_0040}, 0, 1, "R7 fwd");
      run({2'b01, 30'h3FFF_FFF0}, 0, 1, "R7 back");
      run(f_arith(6'b111000, 5'd0, 5'd15, 1, 13'd4), 0, 1, "R8 return");
      run(f_arith(6'b111000, 5'd23, 5'd6, 0, 13'd1), 0, 1, "R8 link");
      run(f_arith(6'b111000, 5'd24, 5'd5, 1, 13'h1FFC), 0, 1, "R8 neg");

      // loads and stores (R10)
      run(f_mem(6'b000000, 5'd25, 5'd6, 1, 13'h1FFC), 32'hCAFE_F00D, 1, "R10 ld");
      run(f_mem(6'b000000, 5'd26, 5'd4, 0, 13'd7), 32'h0BAD_BEEF, 1, "R10 ld reg");
      run(f_mem(6'b000100, 5'd25, 5'd4, 0, 13'd7), 0, 1, "R10 st");
      run(f_mem(6'b000100, 5'd26, 5'd1, 1, 13'h0100), 0, 1, "R10 st imm");
      run(f_mem(6'b000000, 5'd0, 5'd2, 1, 13'd0), 32'h1111_2222, 1, "R10 ld r0");

      // undefined encodings (R1)
      run(f_arith(6'b000001, 5'd9, 5'd1, 0, 13'd2), 0, 1, "R1 op3");
      run(f_arith(6'b111111, 5'd9, 5'd3, 0, 13'd3), 0, 1, "R1 op3");
      run(f_mem(6'b000010, 5'd9, 5'd1, 0, 13'd2), 0, 1, "R1 mem");
      run({2'b00, 5'd9, 3'b000, 22'h1234}, 0, 1, "R1 op2");
      run(f_mem(6'b000100, 5'd9, 5'd0, 1, 13'd0), 0, 1, "R1 readback");

      // invalid slot (R11)
      run(f_arith(6'b010000, 5'd10, 5'd3, 0, 13'd3), 0, 0, "R11 idle alu");
      run(f_mem(6'b000000, 5'd11, 5'd3, 0, 13'd3), 32'h5555_5555, 0, "R11 idle ld");
      run(f_mem(6'b000100, 5'd10, 5'd0, 1, 13'd0), 0, 1, "R11 readback");
      run(f_mem(6'b000100, 5'd11, 5'd0, 1, 13'd0), 0, 1, "R11 readback");

      @(negedge clk);
      chk("R4 final flags", {28'b0, flags_o}, {28'b0, m_fl});
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_P * 150000);
      checks++;
      fails++;
      $display("FAIL R11 watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule